// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the configuration-space registers of a message-signalled interrupt capability for a single function. Software reaches it through a dword-indexed port whose index counts from the capability base. Each write carries four byte enables, and reads return the addressed dword in the same cycle. The block stores the enable bit, the enabled vector count, the message address, the 16-bit message data and, when per-vector masking is built in, the mask and pending words. It exports all of these as decoded fields to an interrupt delivery engine. That engine sets and clears pending bits through two strobe vectors.

Three elaboration parameters fix the layout. One turns 64-bit addressing on or off, one turns per-vector masking on or off, and one sets log2 of the number of vectors the function can use, from 0 to 5. The register positions, the total length and the write masks all follow from these parameters. Software may request more vectors than the function can use; the stored request is then silently reduced to the capable count.

Top module: `msi_cap_regs`

## Requirements
- R1: While reset is low, and after it is released, the enable bit, the enabled-count field, both address words, the data word, the mask and the pending word all read zero. The read-only control fields still report the configuration.
- R2: Dword 0 bits [15:0] read zero. Bits [31:16] are the control word, laid out as follows: bit 16 is the enable, bits 19:17 are the capable log2 count, bits 22:20 are the enabled log2 count, bit 23 is set when 64-bit addressing is built in, bit 24 is set when masking is built in, and bits 31:25 are zero. Only bit 16 and bits 22:20 are writable.
- R3: A written enabled-count value larger than the capable log2 count is stored as the capable log2 count. Smaller or equal values are stored unchanged.
- R4: Dword 1 is the low message address, and its bits [1:0] always read zero. With 64-bit addressing, dword 2 is the fully writable high address word. The exported 64-bit address is {high, low}, and its high half is zero without 64-bit addressing.
- R5: The message data occupies bits [15:0] of dword 3 with 64-bit addressing, or of dword 2 without it. All 16 bits are writable, bits [31:16] of that dword read zero, and writes to them have no effect.
- R6: With masking, the mask word is the dword after the data and the pending word is the dword after the mask. Only mask bits below the capable vector count are writable; the others read zero. Software writes to the pending word have no effect.
- R7: A pend_set bit below the capable count sets the pending bit on the next clock, and a pend_clr bit clears it. When both strobe the same bit, set wins. Strobes at or above the capable count are ignored. Without masking, pending stays zero.
- R8: Each byte of a write changes only the stored bits of the byte lanes whose enable is high. Registers not addressed keep their values.
- R9: Bytes beyond the capability length are ignored on write and read zero. The length is 0x0A, 0x0E, 0x14 or 0x18 bytes for 32-bit/no mask, 64-bit/no mask, 32-bit/mask and 64-bit/mask.
- R10: A write lands on the rising clock edge on which cfg_wr is high. The exported fields and read data show the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_idx | input | 3 | Dword index from capability base |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of dword cfg_idx (combinational) |
| pend_set | input | 32 | Per-vector pending set strobes from the delivery engine |
| pend_clr | input | 32 | Per-vector pending clear strobes from the delivery engine |
| msi_enable | output | 1 | Enable bit |
| vec_en_log2 | output | 3 | Enabled vector count, log2, after clamping |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| vec_pending | output | 32 | Per-vector pending |

## Verification
The hardest situations to reach from the ports are the ones where the layout itself decides the outcome. The same dword index can be the high address in one build, the data word in another, and nothing at all in a third. Two builds therefore share one stimulus bus: a 64-bit build with masking and eight vectors, and a 32-bit build without masking and two vectors. Every write then lands on a register in one build and on a reserved hole or on bytes past the end in the other. The benches sweep all sixteen byte-enable patterns and every enabled-count request, and they hit both pending strobes on the same bit.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   localparam int unsigned IDX_W        = 3;
   localparam int unsigned MAX_VEC_LOG2 = 5;

   // Total capability length in bytes for a given layout.
   function automatic int unsigned cap_len_bytes(input bit a64, input bit pvm);
      if (a64 && pvm)  return 32'h18;
      else if (a64)    return 32'h0E;
      else if (pvm)    return 32'h14;
      else             return 32'h0A;
   endfunction

   // Dword index of the data word; mask and pending follow it.
   function automatic int unsigned data_dword(input bit a64);
      return a64 ? 3 : 2;
   endfunction

   // Bits of the vector span for a given capable log2 count.
   function automatic logic [31:0] vec_span(input int unsigned lg2);
      logic [63:0] wide;
      wide = (64'd1 << (64'd1 << lg2)) - 64'd1;
      return wide[31:0];
   endfunction

endpackage

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
   parameter int unsigned CAP_LOG2 = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   output logic       en,
   output logic [2:0] mme
);

   localparam logic [2:0] CAP = 3'(CAP_LOG2);

   logic [2:0] req;
   assign req = wr_byte[6:4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= 1'b0;
         mme <= 3'd0;
      end else if (wr_en) begin
         en  <= wr_byte[0];
         mme <= (req > CAP) ? CAP : req;
      end
   end

   // R3: stored count never exceeds the capable count
   p_mme_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mme <= CAP));

   // R3: an in-range request is kept as written
   p_mme_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_byte[6:4] <= CAP) |=> (mme == $past(wr_byte[6:4])));

   // R8: no write, no change
   p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({en, mme}));

   // R1: reset clears the writable control fields
   p_ctrl_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!en && mme == 3'd0));

endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs #(
   parameter bit ADDR64 = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  lo_be,
   input  logic [3:0]  hi_be,
   input  logic [1:0]  dat_be,
   input  logic [31:0] wdata,
   output logic [31:0] addr_lo,
   output logic [31:0] addr_hi,
   output logic [15:0] data
);

   // Low address, bits [1:0] are not stored.
   logic [31:2] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else begin
         if (lo_be[0]) lo_q[7:2]   <= wdata[7:2];
         if (lo_be[1]) lo_q[15:8]  <= wdata[15:8];
         if (lo_be[2]) lo_q[23:16] <= wdata[23:16];
         if (lo_be[3]) lo_q[31:24] <= wdata[31:24];
      end
   end
   assign addr_lo = {lo_q, 2'b00};

   generate
      if (ADDR64) begin : g_hi
         logic [31:0] hi_q;
         for (genvar b = 0; b < 4; b++) begin : g_lane
            always_ff @(posedge clk) begin
               if (!rst_n)       hi_q[8*b +: 8] <= '0;
               else if (hi_be[b]) hi_q[8*b +: 8] <= wdata[8*b +: 8];
            end
         end
         assign addr_hi = hi_q;

         // R4: high address lanes follow the written bytes
         p_hi_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hi_be[3] |=> (addr_hi[31:24] == $past(wdata[31:24])));
      end else begin : g_no_hi
         assign addr_hi = '0;
      end
   endgenerate

   logic [15:0] dat_q;
   for (genvar b = 0; b < 2; b++) begin : g_dat
      always_ff @(posedge clk) begin
         if (!rst_n)         dat_q[8*b +: 8] <= '0;
         else if (dat_be[b]) dat_q[8*b +: 8] <= wdata[8*b +: 8];
      end
   end
   assign data = dat_q;

   // R8: untouched address low stays put
   p_lo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_be == 4'b0) |=> $stable(addr_lo));

   // R5: data byte 0 takes the written byte
   p_data_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dat_be[0] |=> (data[7:0] == $past(wdata[7:0])));

   // R8: untouched data stays put
   p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_be == 2'b0) |=> $stable(data));

endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs
   import msi_cap_pkg::*;
#(
   parameter bit          PVMASK   = 1'b1,
   parameter int unsigned CAP_LOG2 = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  mask_be,
   input  logic [31:0] wdata,
   input  logic [31:0] pend_set,
   input  logic [31:0] pend_clr,
   output logic [31:0] mask,
   output logic [31:0] pending
);

   localparam logic [31:0] SPAN = vec_span(CAP_LOG2);

   generate
      if (PVMASK) begin : g_vec
         logic [31:0] mask_q;
         logic [31:0] pend_q;

         for (genvar b = 0; b < 4; b++) begin : g_lane
            always_ff @(posedge clk) begin
               if (!rst_n)
                  mask_q[8*b +: 8] <= '0;
               else if (mask_be[b])
                  mask_q[8*b +: 8] <= wdata[8*b +: 8] & SPAN[8*b +: 8];
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= ((pend_q & ~pend_clr) | pend_set) & SPAN;
         end

         assign mask    = mask_q;
         assign pending = pend_q;

         // R7: a set strobe in range lands on the next edge
         p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|(pend_set & SPAN)) |=>
               ((pending & $past(pend_set & SPAN)) == $past(pend_set & SPAN)));

         // R7: a clear strobe without a set empties the bit
         p_pend_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|(pend_clr & ~pend_set)) |=>
               ((pending & $past(pend_clr & ~pend_set)) == 32'h0));

         // R6: mask bits above the capable count stay zero after a write
         p_mask_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|mask_be) |=> ((mask & ~SPAN) == 32'h0));

         // R8: no lane enabled, no mask change
         p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_be == 4'b0) |=> $stable(mask));
      end else begin : g_no_vec
         assign mask    = '0;
         assign pending = '0;
      end
   endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter bit          ADDR64       = 1'b1,
   parameter bit          PVMASK       = 1'b1,
   parameter int unsigned CAP_VEC_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [3:0]       cfg_be,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic [31:0]      pend_set,
   input  logic [31:0]      pend_clr,
   output logic             msi_enable,
   output logic [2:0]       vec_en_log2,
   output logic [63:0]      msg_addr,
   output logic [15:0]      msg_data,
   output logic [31:0]      vec_mask,
   output logic [31:0]      vec_pending
);

   localparam int unsigned CAP_LEN  = cap_len_bytes(ADDR64, PVMASK);
   localparam int unsigned IDX_DATA = data_dword(ADDR64);
   localparam int unsigned IDX_MASK = IDX_DATA + 1;
   localparam int unsigned IDX_PEND = IDX_DATA + 2;
   localparam logic [2:0]  CAP      = 3'(CAP_VEC_LOG2);

   generate
      if (CAP_VEC_LOG2 > MAX_VEC_LOG2) begin : g_bad_cap
         $error("CAP_VEC_LOG2 must be at most 5");
      end
   endgenerate

   // Byte lanes of the addressed dword that lie inside the capability.
   logic [3:0] lane_live;
   logic [3:0] be_w;

   always_comb begin
      for (int l = 0; l < 4; l++)
         lane_live[l] = ((32'(cfg_idx) << 2) + 32'(l)) < 32'(CAP_LEN);
   end

   assign be_w = cfg_wr ? (cfg_be & lane_live) : 4'b0;

   logic       ctrl_wr;
   logic [3:0] lo_be, hi_be, mask_be;
   logic [1:0] dat_be;

   assign ctrl_wr = be_w[2] && (cfg_idx == 3'd0);
   assign lo_be   = (cfg_idx == 3'd1) ? be_w : 4'b0;
   assign hi_be   = (ADDR64 && cfg_idx == 3'd2) ? be_w : 4'b0;
   assign dat_be  = (cfg_idx == 3'(IDX_DATA)) ? be_w[1:0] : 2'b0;
   assign mask_be = (PVMASK && cfg_idx == 3'(IDX_MASK)) ? be_w : 4'b0;

   logic [31:0] addr_lo, addr_hi;

   msi_ctrl_reg #(.CAP_LOG2(CAP_VEC_LOG2)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctrl_wr),
      .wr_byte (cfg_wdata[23:16]),
      .en      (msi_enable),
      .mme     (vec_en_log2)
   );

   msi_msg_regs #(.ADDR64(ADDR64)) u_msg (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_be   (lo_be),
      .hi_be   (hi_be),
      .dat_be  (dat_be),
      .wdata   (cfg_wdata),
      .addr_lo (addr_lo),
      .addr_hi (addr_hi),
      .data    (msg_data)
   );

   msi_vec_regs #(.PVMASK(PVMASK), .CAP_LOG2(CAP_VEC_LOG2)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_be  (mask_be),
      .wdata    (cfg_wdata),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .mask     (vec_mask),
      .pending  (vec_pending)
   );

   assign msg_addr = {addr_hi, addr_lo};

   always_comb begin
      cfg_rdata = '0;
      if (cfg_idx == 3'd0)
         cfg_rdata = {7'b0, PVMASK, ADDR64, vec_en_log2, CAP, msi_enable, 16'h0};
      else if (cfg_idx == 3'd1)
         cfg_rdata = addr_lo;
      else if (ADDR64 && cfg_idx == 3'd2)
         cfg_rdata = addr_hi;
      else if (cfg_idx == 3'(IDX_DATA))
         cfg_rdata = {16'h0, msg_data};
      else if (PVMASK && cfg_idx == 3'(IDX_MASK))
         cfg_rdata = vec_mask;
      else if (PVMASK && cfg_idx == 3'(IDX_PEND))
         cfg_rdata = vec_pending;
   end

   // R9: dwords wholly past the end never update a register
   p_oob_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cfg_idx) * 4 >= 32'(CAP_LEN)) |=>
         $stable({msi_enable, vec_en_log2, msg_addr, msg_data, vec_mask}));

   // R10: enable follows a control write on the next edge
   p_enable_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be[2] && cfg_idx == 3'd0) |=> (msi_enable == $past(cfg_wdata[16])));

endmodule

// File: tb/msi_cap_regs_bench.sv
`timescale 1ns/100ps
module msi_cap_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] pend_set = '0;
   logic [31:0] pend_clr = '0;

   logic [31:0] rd_a, rd_b;
   logic        en_a, en_b;
   logic [2:0]  cnt_a, cnt_b;
   logic [63:0] addr_a, addr_b;
   logic [15:0] dat_a, dat_b;
   logic [31:0] mask_a, mask_b, pend_a, pend_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   // Build A: 64-bit, masking, 8 vectors.
   msi_cap_regs #(.ADDR64(1'b1), .PVMASK(1'b1), .CAP_VEC_LOG2(3)) u_msi_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .pend_set(pend_set), .pend_clr(pend_clr),
      .msi_enable(en_a), .vec_en_log2(cnt_a), .msg_addr(addr_a), .msg_data(dat_a),
      .vec_mask(mask_a), .vec_pending(pend_a));

   // Build B: 32-bit, no masking, 2 vectors.
   msi_cap_regs #(.ADDR64(1'b0), .PVMASK(1'b0), .CAP_VEC_LOG2(1)) u_msi_cap_regs_b (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .pend_set(pend_set), .pend_clr(pend_clr),
      .msi_enable(en_b), .vec_en_log2(cnt_b), .msg_addr(addr_b), .msg_data(dat_b),
      .vec_mask(mask_b), .vec_pending(pend_b));

   function automatic logic [31:0] ctrl_word(input bit en, input int unsigned cnt,
                                             input bit a64, input bit pvm,
                                             input int unsigned cap);
      return (32'(pvm) << 24) | (32'(a64) << 23) | (32'(cnt) << 20) |
             (32'(cap) << 17) | (32'(en) << 16);
   endfunction

   function automatic logic [31:0] byte_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input int unsigned idx, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_idx = 3'(idx); cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic rd(input int unsigned idx, output logic [31:0] a, output logic [31:0] b);
      cfg_idx = 3'(idx);
      #1;
      a = rd_a; b = rd_b;
   endtask

   task automatic pend(input logic [31:0] s, input logic [31:0] c);
      @(negedge clk);
      pend_set = s; pend_clr = c;
      @(negedge clk);
      pend_set = '0; pend_clr = '0;
   endtask

   task automatic check_reset_state(input string tag);
      logic [31:0] a, b;
      rd(0, a, b);
      check("R1", {tag, " ctrl A"}, a, ctrl_word(0, 0, 1, 1, 3));
      check("R1", {tag, " ctrl B"}, b, ctrl_word(0, 0, 0, 0, 1));
      for (int i = 1; i < 8; i++) begin
         rd(i, a, b);
         check("R1", $sformatf("%s dword%0d A", tag, i), a, 0);
         check("R1", $sformatf("%s dword%0d B", tag, i), b, 0);
      end
      check("R1", {tag, " outputs A"}, {en_a, cnt_a, addr_a, dat_a, mask_a, pend_a}, 0);
      check("R1", {tag, " outputs B"}, {en_b, cnt_b, addr_b, dat_b, mask_b, pend_b}, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] a, b;
      logic [31:0] snap_a [8];
      logic [31:0] snap_b [8];

      repeat (3) @(negedge clk);
      check_reset_state("reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("after release");

      // R2/R3: sweep every enable and requested count, with ones on read-only bits.
      for (int v = 0; v < 16; v++) begin
         bit en;
         int unsigned req;
         en  = v[0];
         req = v[3:1];
         wr(0, 4'b1111, {8'hFF, 1'b1, 3'(req), 3'b111, en, 16'hFFFF});
         rd(0, a, b);
         check("R3", $sformatf("ctrl A req %0d", req), a,
               ctrl_word(en, (req > 3) ? 3 : req, 1, 1, 3));
         check("R2", $sformatf("ctrl B req %0d", req), b,
               ctrl_word(en, (req > 1) ? 1 : req, 0, 0, 1));
         check("R10", "enable out A", en_a, en);
         check("R3", "count out B", cnt_b, (req > 1) ? 1 : req);
      end

      // R2: lane 2 disabled leaves the control word untouched.
      wr(0, 4'b1011, 32'h0000_0000);
      rd(0, a, b);
      check("R8", "ctrl A lane off", a, ctrl_word(1, 3, 1, 1, 3));

      // R4/R5: address low, then dword 2 (high address in A, data in B).
      wr(1, 4'b1111, 32'h1234_5677);
      wr(2, 4'b1111, 32'hCAFE_F00D);
      rd(1, a, b);
      check("R4", "addr lo A", a, 32'h1234_5674);
      check("R4", "addr lo B", b, 32'h1234_5674);
      rd(2, a, b);
      check("R4", "addr hi A", a, 32'hCAFE_F00D);
      check("R5", "data B", b, 32'h0000_F00D);
      check("R4", "msg addr A", addr_a, 64'hCAFE_F00D_1234_5674);
      check("R4", "msg addr B", addr_b, 64'h0000_0000_1234_5674);
      check("R5", "msg data B", dat_b, 16'hF00D);

      // R5/R9: dword 3 is data in A and past the end in B.
      wr(3, 4'b1111, 32'h5555_ABCD);
      rd(3, a, b);
      check("R5", "data A", a, 32'h0000_ABCD);
      check("R9", "dword3 B", b, 0);
      check("R9", "data B kept", dat_b, 16'hF00D);

      // R8: byte-enable sweep on the data word of A and the address low of both.
      for (int be = 0; be < 16; be++) begin
         wr(3, 4'b1111, 32'h0);
         wr(1, 4'b1111, 32'h0);
         wr(3, 4'(be), 32'hFFFF_FFFF);
         wr(1, 4'(be), 32'hFFFF_FFFF);
         rd(3, a, b);
         check("R8", $sformatf("data A be %0h", be), a, byte_mask(4'(be)) & 32'h0000_FFFF);
         rd(1, a, b);
         check("R8", $sformatf("addr lo B be %0h", be), b, byte_mask(4'(be)) & 32'hFFFF_FFFC);
      end

      // R6: mask span and byte enables.
      for (int be = 0; be < 16; be++) begin
         wr(4, 4'b1111, 32'h0);
         wr(4, 4'(be), 32'hFFFF_FFFF);
         rd(4, a, b);
         check("R6", $sformatf("mask A be %0h", be), a, be[0] ? 32'hFF : 32'h0);
         check("R9", "mask B", mask_b, 0);
      end

      // R7: pending strobes.
      pend(32'hFFFF_FF05, 32'h0);
      rd(5, a, b);
      check("R7", "pending set", a, 32'h05);
      check("R7", "pending B", pend_b, 0);
      pend(32'h02, 32'h01);
      check("R7", "set and clear", pend_a, 32'h06);
      pend(32'h04, 32'h04);
      check("R7", "set wins", pend_a, 32'h06);
      pend(32'h0, 32'hFFFF_FFFF);
      check("R7", "clear all", pend_a, 32'h0);
      pend(32'h81, 32'h0);
      wr(5, 4'b1111, 32'h0);
      rd(5, a, b);
      check("R6", "pending ignores write", a, 32'h81);

      // R9: writes past the end in both builds and to B's upper data bytes.
      for (int i = 0; i < 8; i++) begin
         rd(i, a, b);
         snap_a[i] = a;
         snap_b[i] = b;
      end
      wr(6, 4'b1111, 32'hFFFF_FFFF);
      wr(7, 4'b1111, 32'hFFFF_FFFF);
      wr(2, 4'b1100, 32'h0000_0000);
      for (int i = 0; i < 8; i++) begin
         rd(i, a, b);
         if (i != 2) check("R9", $sformatf("A dword%0d kept", i), a, snap_a[i]);
         else        check("R4", "A hi upper lanes written", a, snap_a[2] & 32'h0000_FFFF);
         check("R9", $sformatf("B dword%0d kept", i), b, snap_b[i]);
      end
      for (int i = 3; i < 8; i++) begin
         wr(i, 4'b1111, 32'hFFFF_FFFF);
         rd(i, a, b);
         check("R9", $sformatf("B dword%0d zero", i), b, 0);
      end
      rd(2, a, b);
      check("R5", "B data upper reads zero", b, snap_b[2]);

      // R1: reset in the middle of operation.
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state("mid reset");
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule